// File: doc/BRIEF.md
# Register Access Protection Filter

This block guards one 4 KB register block on a configuration bus. Each request carries a byte address, a read or write flag, write data and three attributes: privileged, secure, and whether it comes from the external interface. The block holds a protection bitmap with one bit per 32-bit register. It decides in the same cycle whether the access may proceed. An allowed access reaches a small register file, the bitmap window or the error registers. A refused access is blocked and answered with an error flag.

Every refusal sets bits in a 32-bit cause register. The first refusal after the cause register was last empty also records the offending address. Software reads both registers and acknowledges by writing ones to the cause bits it has handled. After reset every register is secured, and software opens registers one at a time by clearing their bits through the bitmap window.

Address map (byte offsets inside the block): data registers at 0x000-0x03C (16 words; 0x03C is write-only), bitmap words at 0xF00-0xF7C, cause register at 0xF80, error-address register at 0xF84 (read-only). Every other offset is unmapped.

Top module: `access_guard`

## Requirements
- R1: After reset every protection bit is 1, the cause register and the data registers are 0, and each bitmap word reads 0xFFFFFFFF. A non-secure access to any mapped register is therefore refused.
- R2: A register at byte offset A owns protection bit A>>2. That bit sits in bitmap word (A>>2)/32 at offset 0xF00 + 4*word, at bit position (A>>2)%32. A bit of 0 lets any access through, whatever its privilege and security attributes.
- R3: For a register whose bit is 1, a non-external access that is not privileged sets cause bit 0 (read) or bit 3 (write). One that is not secure sets bit 1 (read) or bit 4 (write). Both bits may be set by one access.
- R4: An offset of 4096 or more, a misaligned offset, or an offset outside the address map is unmapped. Reading it sets cause bit 2. Writing it sets bit 5, or bit 17 when the write comes from the external interface. No protection check is made for it.
- R5: An external-interface write to a register whose bit is 1 sets cause bit 16 instead of bits 3 and 4 when it is unprivileged or non-secure.
- R6: A read of the write-only data register 0x03C sets cause bit 24. A write to the error-address register 0xF84 sets bit 25.
- R7: A refused access raises the error flag in the cycle of the request. A refused read returns 0, and a refused write changes nothing. An allowed read returns the register contents with the error flag low. The error flag is low when no request is present.
- R8: New cause bits are ORed into the cause register. Cause bits other than 0-5, 16, 17, 24 and 25 are always 0. An allowed write to 0xF80 clears exactly the bits written as 1.
- R9: The error-address register takes the request's byte address on a refusal made while the cause register is 0. It keeps that value through later refusals until the cause is cleared to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request present this cycle |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | ADDR_W | Byte offset of the access |
| reqWdata | input | 32 | Write data |
| reqPriv | input | 1 | Access is privileged |
| reqSecure | input | 1 | Access is secure |
| reqExt | input | 1 | Access comes from the external interface |
| rspRdata | output | 32 | Read data, 0 when refused |
| rspErr | output | 1 | Access refused, same cycle as the request |

## Verification
On every cycle the assertions check port-level rules that need no memory of earlier cycles. A refused read returns zero. Misaligned and out-of-block offsets are always refused, as are writes to the error-address register and reads of the write-only register. No error is flagged without a request. The bench scenarios cover everything that depends on stored state. These are: the reset value of the bitmap, opening registers through bitmap words at different positions, how cause bits build up and how write-one-to-clear releases them, the rule that the error address is captured only on the first refusal, and the proof that a blocked write left the register unchanged.

// File: rtl/access_guard_pkg.sv
package access_guard_pkg;

  localparam int CAUSE_W = 32;

  // cause bit positions (software decodes these)
  localparam int C_RD_PRIV   = 0;
  localparam int C_RD_SEC    = 1;
  localparam int C_RD_UNMAP  = 2;
  localparam int C_WR_PRIV   = 3;
  localparam int C_WR_SEC    = 4;
  localparam int C_WR_UNMAP  = 5;
  localparam int C_EXT_SEC   = 16;
  localparam int C_EXT_UNMAP = 17;
  localparam int C_RD_WO     = 24;
  localparam int C_WR_RO     = 25;

  localparam logic [CAUSE_W-1:0] CAUSE_MASK =
    (CAUSE_W'(1) << C_RD_PRIV)  | (CAUSE_W'(1) << C_RD_SEC)   |
    (CAUSE_W'(1) << C_RD_UNMAP) | (CAUSE_W'(1) << C_WR_PRIV)  |
    (CAUSE_W'(1) << C_WR_SEC)   | (CAUSE_W'(1) << C_WR_UNMAP) |
    (CAUSE_W'(1) << C_EXT_SEC)  | (CAUSE_W'(1) << C_EXT_UNMAP) |
    (CAUSE_W'(1) << C_RD_WO)    | (CAUSE_W'(1) << C_WR_RO);

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_DATA,
    SEL_MAP,
    SEL_CAUSE,
    SEL_EADDR
  } regSel_e;

  // control -> datapath strobes
  typedef struct packed {
    logic               commit;  // allowed write this cycle
    logic               rdEn;    // allowed read this cycle
    regSel_e            sel;     // target register class
    logic [CAUSE_W-1:0] viol;    // new cause bits (zero when allowed)
  } strobe_t;

endpackage

// File: rtl/access_guard_ctrl.sv
module access_guard_ctrl
  import access_guard_pkg::*;
#(
  parameter int ADDR_W      = 16,
  parameter int BLOCK_BYTES = 4096,
  parameter int NUM_DATA    = 16,
  parameter int WO_IDX      = 15,
  parameter int MAP_BASE    = 'hF00,
  parameter int CAUSE_OFS   = 'hF80,
  parameter int EADDR_OFS   = 'hF84,
  localparam int NUM_WORDS  = BLOCK_BYTES / 4,
  localparam int WIDX_W     = $clog2(NUM_WORDS),
  localparam int MAP_WORDS  = NUM_WORDS / 32,
  localparam int MAP_FIRST  = MAP_BASE / 4
) (
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic              reqPriv,
  input  logic              reqSecure,
  input  logic              reqExt,
  input  logic              protBit,
  output logic [WIDX_W-1:0] wordIdx,
  output strobe_t           stb
);

  logic    inBlock, aligned, mapped, privFail, secFail;
  regSel_e sel;

  assign wordIdx = reqAddr[WIDX_W+1:2];
  assign inBlock = reqAddr < ADDR_W'(BLOCK_BYTES);
  assign aligned = reqAddr[1:0] == 2'b00;

  always_comb begin
    sel = SEL_NONE;
    if (wordIdx < WIDX_W'(NUM_DATA))
      sel = SEL_DATA;
    else if (wordIdx >= WIDX_W'(MAP_FIRST) && wordIdx < WIDX_W'(MAP_FIRST + MAP_WORDS))
      sel = SEL_MAP;
    else if (wordIdx == WIDX_W'(CAUSE_OFS / 4))
      sel = SEL_CAUSE;
    else if (wordIdx == WIDX_W'(EADDR_OFS / 4))
      sel = SEL_EADDR;
  end

  assign mapped   = inBlock && aligned && (sel != SEL_NONE);
  assign privFail = protBit && !reqPriv;
  assign secFail  = protBit && !reqSecure;

  logic [CAUSE_W-1:0] viol;
  always_comb begin
    viol = '0;
    if (reqValid) begin
      if (!mapped) begin
        if (!reqWrite)   viol[C_RD_UNMAP]  = 1'b1;
        else if (reqExt) viol[C_EXT_UNMAP] = 1'b1;
        else             viol[C_WR_UNMAP]  = 1'b1;
      end else if (reqWrite) begin
        if (reqExt) viol[C_EXT_SEC] = privFail || secFail;
        else begin
          viol[C_WR_PRIV] = privFail;
          viol[C_WR_SEC]  = secFail;
        end
        if (sel == SEL_EADDR) viol[C_WR_RO] = 1'b1;
      end else begin
        viol[C_RD_PRIV] = privFail;
        viol[C_RD_SEC]  = secFail;
        if (sel == SEL_DATA && wordIdx == WIDX_W'(WO_IDX)) viol[C_RD_WO] = 1'b1;
      end
    end
  end

  assign stb.viol   = viol;
  assign stb.sel    = sel;
  assign stb.commit = reqValid && reqWrite && mapped && (viol == '0);
  assign stb.rdEn   = reqValid && !reqWrite && mapped && (viol == '0);

endmodule

// File: rtl/access_guard_dp.sv
module access_guard_dp
  import access_guard_pkg::*;
#(
  parameter int ADDR_W      = 16,
  parameter int BLOCK_BYTES = 4096,
  parameter int NUM_DATA    = 16,
  parameter int MAP_BASE    = 'hF00,
  localparam int NUM_WORDS  = BLOCK_BYTES / 4,
  localparam int WIDX_W     = $clog2(NUM_WORDS),
  localparam int MAP_WORDS  = NUM_WORDS / 32,
  localparam int MAP_FIRST  = MAP_BASE / 4,
  localparam int MSLOT_W    = $clog2(MAP_WORDS),
  localparam int DIDX_W     = $clog2(NUM_DATA)
) (
  input  logic               clk,
  input  logic               rstN,
  input  strobe_t            stb,
  input  logic [WIDX_W-1:0]  wordIdx,
  input  logic [ADDR_W-1:0]  reqAddr,
  input  logic [31:0]        reqWdata,
  output logic               protBit,
  output logic [31:0]        rspRdata
);

  logic [MAP_WORDS-1:0][31:0] mapQ;
  logic [NUM_DATA-1:0][31:0]  dataQ;
  logic [CAUSE_W-1:0]         causeQ;
  logic [ADDR_W-1:0]          errAddrQ;
  logic [WIDX_W-1:0]          mapSlot;

  assign mapSlot = wordIdx - WIDX_W'(MAP_FIRST);

  // protection bitmap, one 32-bit word per 32 registers, all secured at reset
  for (genvar g = 0; g < MAP_WORDS; g++) begin : g_map
    logic [31:0] slotQ;
    always_ff @(posedge clk) begin
      if (!rstN) slotQ <= '1;
      else if (stb.commit && stb.sel == SEL_MAP && mapSlot == WIDX_W'(g))
        slotQ <= reqWdata;
    end
    assign mapQ[g] = slotQ;
  end

  // guarded register file
  for (genvar g = 0; g < NUM_DATA; g++) begin : g_data
    logic [31:0] regQ;
    always_ff @(posedge clk) begin
      if (!rstN) regQ <= '0;
      else if (stb.commit && stb.sel == SEL_DATA && wordIdx == WIDX_W'(g))
        regQ <= reqWdata;
    end
    assign dataQ[g] = regQ;
  end

  assign protBit = mapQ[wordIdx[WIDX_W-1:5]][wordIdx[4:0]];

  logic [CAUSE_W-1:0] clrBits;
  assign clrBits = (stb.commit && stb.sel == SEL_CAUSE) ? (reqWdata & CAUSE_MASK) : '0;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      causeQ   <= '0;
      errAddrQ <= '0;
    end else begin
      causeQ <= (causeQ & ~clrBits) | stb.viol;
      if (stb.viol != '0 && causeQ == '0) errAddrQ <= reqAddr;
    end
  end

  always_comb begin
    rspRdata = '0;
    if (stb.rdEn) begin
      unique case (stb.sel)
        SEL_DATA:  rspRdata = dataQ[wordIdx[DIDX_W-1:0]];
        SEL_MAP:   rspRdata = mapQ[mapSlot[MSLOT_W-1:0]];
        SEL_CAUSE: rspRdata = causeQ;
        SEL_EADDR: rspRdata = 32'(errAddrQ);
        default:   rspRdata = '0;
      endcase
    end
  end

endmodule

// File: rtl/access_guard.sv
module access_guard
  import access_guard_pkg::*;
#(
  parameter int ADDR_W      = 16,
  parameter int BLOCK_BYTES = 4096,
  parameter int NUM_DATA    = 16,
  parameter int WO_IDX      = 15,
  parameter int MAP_BASE    = 'hF00,
  parameter int CAUSE_OFS   = 'hF80,
  parameter int EADDR_OFS   = 'hF84,
  localparam int WIDX_W     = $clog2(BLOCK_BYTES / 4)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [31:0]       reqWdata,
  input  logic              reqPriv,
  input  logic              reqSecure,
  input  logic              reqExt,
  output logic [31:0]       rspRdata,
  output logic              rspErr
);

  strobe_t           stb;
  logic [WIDX_W-1:0] wordIdx;
  logic              protBit;

  access_guard_ctrl #(
    .ADDR_W(ADDR_W), .BLOCK_BYTES(BLOCK_BYTES), .NUM_DATA(NUM_DATA),
    .WO_IDX(WO_IDX), .MAP_BASE(MAP_BASE), .CAUSE_OFS(CAUSE_OFS),
    .EADDR_OFS(EADDR_OFS)
  ) u_ctrl (
    .reqValid(reqValid), .reqWrite(reqWrite), .reqAddr(reqAddr),
    .reqPriv(reqPriv), .reqSecure(reqSecure), .reqExt(reqExt),
    .protBit(protBit), .wordIdx(wordIdx), .stb(stb)
  );

  access_guard_dp #(
    .ADDR_W(ADDR_W), .BLOCK_BYTES(BLOCK_BYTES), .NUM_DATA(NUM_DATA),
    .MAP_BASE(MAP_BASE)
  ) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .wordIdx(wordIdx),
    .reqAddr(reqAddr), .reqWdata(reqWdata), .protBit(protBit),
    .rspRdata(rspRdata)
  );

  assign rspErr = stb.viol != '0;

endmodule

// File: rtl/access_guard_chk.sv
module access_guard_chk #(
  parameter int ADDR_W      = 16,
  parameter int BLOCK_BYTES = 4096,
  parameter int WO_IDX      = 15,
  parameter int EADDR_OFS   = 'hF84
) (
  input logic              clk,
  input logic              rstN,
  input logic              reqValid,
  input logic              reqWrite,
  input logic [ADDR_W-1:0] reqAddr,
  input logic [31:0]       rspRdata,
  input logic              rspErr
);

  a_r7_blocked_read_zero: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !reqWrite && rspErr) |-> (rspRdata == 32'd0));

  a_r7_idle_no_error: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |-> !rspErr);

  a_r4_unmapped_refused: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && (reqAddr[1:0] != 2'b00 || reqAddr >= ADDR_W'(BLOCK_BYTES))) |-> rspErr);

  a_r6_ro_write_refused: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqWrite && reqAddr == ADDR_W'(EADDR_OFS)) |-> rspErr);

  a_r6_wo_read_refused: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !reqWrite && reqAddr == ADDR_W'(WO_IDX * 4)) |-> rspErr);

endmodule

bind access_guard access_guard_chk #(
  .ADDR_W(ADDR_W), .BLOCK_BYTES(BLOCK_BYTES), .WO_IDX(WO_IDX), .EADDR_OFS(EADDR_OFS)
) u_chk (
  .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
  .reqAddr(reqAddr), .rspRdata(rspRdata), .rspErr(rspErr)
);

// File: tb/access_guard_tb.sv
module access_guard_tb;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0, reqWrite = 1'b0;
  logic [15:0] reqAddr = '0;
  logic [31:0] reqWdata = '0;
  logic        reqPriv = 1'b0, reqSecure = 1'b0, reqExt = 1'b0;
  logic [31:0] rspRdata;
  logic        rspErr;

  int nChecks = 0;
  int nFails  = 0;
  logic        gotErr;
  logic [31:0] gotRd;

  always #10 clk = ~clk;  // 50 MHz

  access_guard u_dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqAddr(reqAddr), .reqWdata(reqWdata), .reqPriv(reqPriv),
    .reqSecure(reqSecure), .reqExt(reqExt), .rspRdata(rspRdata), .rspErr(rspErr)
  );

  typedef struct packed {
    logic        wr;
    logic [15:0] addr;
    logic [31:0] wdata;
    logic        priv;
    logic        sec;
    logic        ext;
    logic        expErr;
    logic        chkRd;
    logic [31:0] expRd;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 32;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 16'hF80, 32'h0,        1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 32'h0,        8'd1}, // R1 cause empty
    '{1'b0, 16'h000, 32'h0,        1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 32'h0,        8'd1}, // R1 secured after reset
    '{1'b1, 16'h000, 32'hA5A50001, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 32'h0,        8'd7}, // R7 allowed write
    '{1'b0, 16'h000, 32'h0,        1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 32'hA5A50001, 8'd7}, // R7 allowed read
    '{1'b1, 16'h004, 32'h11111111, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 32'h0,        8'd3}, // R3 unpriv write
    '{1'b0, 16'h004, 32'h0,        1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 32'h0,        8'd7}, // R7 blocked write left no trace
    '{1'b0, 16'hF80, 32'h0,        1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 32'h0000000A, 8'd8}, // R8 bits 1,3 accumulate
    '{1'b0, 16'hF84, 32'h0,        1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 32'h0,        8'd9}, // R9 first address held
    '{1'b1, 16'hF80, 32'hFFFFFFFF, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 32'h0,        8'd8}, // R8 clear all
    '{1'b0, 16'hF80, 32'h0,        1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 32'h0,        8'd8}, // R8 cleared
    '{1'b1, 16'h008, 32'h0,        1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 32'h0,        8'd5}, // R5 ext non-secure write
    '{1'b0, 16'h011, 32'h0,        1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 32'h0,        8'd4}, // R4 misaligned read
    '{1'b1, 16'h2000,32'h0,        1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 32'h0,        8'd4}, // R4 ext out of block
    '{1'b1, 16'h100, 32'h0,        1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 32'h0,        8'd4}, // R4 hole in map
    '{1'b0, 16'h03C, 32'h0,        1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 32'h0,        8'd6}, // R6 write-only read
    '{1'b1, 16'hF84, 32'h0,        1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 32'h0,        8'd6}, // R6 read-only write
    '{1'b0, 16'hF80, 32'h0,        1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 32'h03030024, 8'd8}, // R8 bits 2,5,16,17,24,25
    '{1'b0, 16'hF84, 32'h0,        1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 32'h00000008, 8'd9}, // R9 captured 0x008
    '{1'b1, 16'hF80, 32'h00000024, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 32'h0,        8'd8}, // R8 partial clear
    '{1'b0, 16'hF80, 32'h0,        1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 32'h03030000, 8'd8}, // R8 only written bits gone
    '{1'b1, 16'hF80, 32'hFFFFFFFF, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 32'h0,        8'd8}, // R8 clear all
    '{1'b1, 16'hF00, 32'hFFFFFFFD, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 32'h0,        8'd2}, // R2 open reg 1
    '{1'b0, 16'hF00, 32'h0,        1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 32'hFFFFFFFD, 8'd2}, // R2 word readback
    '{1'b1, 16'h004, 32'h00001234, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 32'h0,        8'd2}, // R2 open write
    '{1'b0, 16'h004, 32'h0,        1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 32'h00001234, 8'd2}, // R2 open read
    '{1'b0, 16'h000, 32'h0,        1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 32'h0,        8'd3}, // R3 bits 0 and 1
    '{1'b1, 16'h000, 32'h0000DEAD, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 32'h0,        8'd3}, // R3 bit 4
    '{1'b0, 16'h000, 32'h0,        1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 32'hA5A50001, 8'd7}, // R7 refused write no effect
    '{1'b0, 16'hF80, 32'h0,        1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 32'h00000013, 8'd3}, // R3 cause 0x13
    '{1'b0, 16'hF84, 32'h0,        1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 32'h0,        8'd9}, // R9 recaptured 0x000
    '{1'b1, 16'h03C, 32'hCAFE0000, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 32'h0,        8'd6}, // R6 write-only accepts write
    '{1'b1, 16'hF80, 32'hFFFFFFFF, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 32'h0,        8'd8}  // R8 clear all
  };

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
    end
  endtask

  task automatic access(input logic wr, input logic [15:0] a, input logic [31:0] d,
                        input logic p, input logic s, input logic e);
    @(negedge clk);
    reqValid = 1'b1; reqWrite = wr; reqAddr = a; reqWdata = d;
    reqPriv = p; reqSecure = s; reqExt = e;
    #2;
    gotErr = rspErr;
    gotRd  = rspRdata;
    @(posedge clk);
    #1;
    reqValid = 1'b0; reqWrite = 1'b0; reqExt = 1'b0;
  endtask

  task automatic finishRun();
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nChecks++;
    nFails++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;

    // R7: idle, no error
    @(negedge clk);
    check(rspErr == 1'b0, "R7 idle error flag", 32'(rspErr), 32'd0);

    for (int i = 0; i < NV; i++) begin
      access(VECS[i].wr, VECS[i].addr, VECS[i].wdata, VECS[i].priv, VECS[i].sec, VECS[i].ext);
      check(gotErr == VECS[i].expErr, $sformatf("R%0d vec %0d err", VECS[i].req, i),
            32'(gotErr), 32'(VECS[i].expErr));
      if (VECS[i].chkRd)
        check(gotRd == VECS[i].expRd, $sformatf("R%0d vec %0d rdata", VECS[i].req, i),
              gotRd, VECS[i].expRd);
    end

    // R2: open the cause register (index 992 = word 31, bit 0) to non-secure access
    access(1'b1, 16'hF7C, 32'hFFFFFFFE, 1'b1, 1'b1, 1'b0);
    check(gotErr == 1'b0, "R2 write bitmap word 31", 32'(gotErr), 32'd0);
    access(1'b0, 16'hF80, 32'h0, 1'b0, 1'b0, 1'b0);
    check(gotErr == 1'b0, "R2 open cause read err", 32'(gotErr), 32'd0);
    check(gotRd == 32'h0, "R2 open cause read data", gotRd, 32'h0);
    access(1'b0, 16'hF84, 32'h0, 1'b0, 1'b0, 1'b0);
    check(gotErr == 1'b1, "R2 neighbour bit still secured", 32'(gotErr), 32'd1);

    // R1: reset again, state returns to fully secured
    @(negedge clk);
    rstN = 1'b0;
    repeat (2) @(posedge clk);
    #1 rstN = 1'b1;
    access(1'b0, 16'h004, 32'h0, 1'b0, 1'b0, 1'b0);
    check(gotErr == 1'b1, "R1 reg 1 secured again", 32'(gotErr), 32'd1);
    access(1'b0, 16'h004, 32'h0, 1'b1, 1'b1, 1'b0);
    check(gotRd == 32'h0, "R1 data cleared by reset", gotRd, 32'h0);
    access(1'b0, 16'hF00, 32'h0, 1'b1, 1'b1, 1'b0);
    check(gotRd == 32'hFFFFFFFF, "R1 bitmap word 0 all ones", gotRd, 32'hFFFFFFFF);
    access(1'b0, 16'hF7C, 32'h0, 1'b1, 1'b1, 1'b0);
    check(gotRd == 32'hFFFFFFFF, "R1 bitmap word 31 all ones", gotRd, 32'hFFFFFFFF);
    access(1'b0, 16'hF80, 32'h0, 1'b1, 1'b1, 1'b0);
    check(gotRd == 32'h00000003, "R3 cause after reset then refusal", gotRd, 32'h00000003);

    finishRun();
  end

endmodule